// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the raster timing for a TFT panel. Software sets it up through a small write port. Three timing registers give the horizontal and vertical geometry and the output polarities. A control register starts and stops the scan. A frame base register holds the address of the next frame. The block counts pixels along each line and lines down each frame, advancing only in cycles where the pixel clock enable input is high. From the two counters it drives hsync, vsync, a data-enable and a per-pixel strobe.

The frame base address is written into a shadow register. The block copies it into the live address output at the first pixel step of vertical blanking, so an address change never lands in the middle of a frame. On that same step a status bit is set. The status bit raises an interrupt unless its enable bit masks it, and software clears it by writing a one to a clear register. Pixel fetch and generation of the pixel clock itself are left to neighbouring logic.

Top module: `lcd_raster_timer`

## Requirements
- R1: After reset, hsync, vsync, de, pix_strobe, irq, lcd_power and frame_base are all zero.
- R2: Write address 0 sets the horizontal timing.
  - Bits [7:2] hold active width/16 minus 1, so the active width is 16 pixels per step.
  - Bits [23:16] hold front porch minus 1.
  - Bits [15:8] hold sync width minus 1.
  - Bits [31:24] hold back porch minus 1.
  - Each line runs active pixels, then front porch, then hsync, then back porch.
- R3: Write address 1 sets the vertical timing.
  - Bits [9:0] hold active lines minus 1.
  - Bits [23:16] hold the front porch in lines, stored as is with no bias.
  - Bits [15:10] hold vsync width minus 1.
  - Bits [31:24] hold the back porch in lines, stored as is with no bias.
  - Each frame runs active lines, front porch, vsync, back porch, in that order.
- R4: de is asserted exactly while the pixel counter is inside the active width and the line counter is inside the active lines.
- R5: Write address 2 sets the polarities and a line length limit.
  - Bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts de.
  - Bit 3 is driven unchanged on pclk_edge_inv.
  - Bits [25:16] hold the clocks-per-line limit used by R6.
- R6: pix_strobe is high only in a cycle that meets all of these:
  - pix_en is high;
  - the current position is an active pixel on an active line;
  - the pixel index is not greater than the clocks-per-line field.
- R7: While pix_en is low the counters hold, so hsync, vsync and de do not change.
- R8: Write address 3 is the control register.
  - Bit 0 enables the scan and bit 1 drives lcd_power.
  - While the scan is disabled, both counters are held at zero and hsync, vsync and de sit at their inactive levels, which are the inversion bits.
  - Scanning restarts from pixel 0 of line 0.
- R9: Write address 4 loads the shadow frame base with bits [1:0] forced to zero.
  - frame_base takes the shadow value only on the pixel step from the last pixel of the last active line into blanking.
  - frame_base holds its value at every other time.
- R10: The status bit sets on the same step that frame_base is loaded.
  - irq is the status bit ANDed with bit 0 of write address 5, the interrupt enable.
  - Writing a one in bit 0 of write address 6 clears the status bit.
  - The status bit is kept while it is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_en | input | 1 | Pixel clock enable; counters advance when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity per R5 |
| vsync | output | 1 | Vertical sync, polarity per R5 |
| de | output | 1 | Data enable, polarity per R5 |
| pix_strobe | output | 1 | Active-high strobe for each delivered pixel |
| pclk_edge_inv | output | 1 | Selected pixel clock output edge |
| lcd_power | output | 1 | Panel power control |
| irq | output | 1 | Masked next-base-taken interrupt |
| frame_base | output | 32 | Live frame base address |

## Verification
The assertions assume two things about the inputs. First, the timing registers are rewritten only while the scan is disabled. Second, the shadow base is never written on the same cycle as the blanking step that adopts it. The stimulus keeps to both. It programs each geometry with the control register at zero, and it issues register writes only while pix_en is low, so no counter can move during a write. With both rules met, the output levels seen while disabled, the strobe staying inside data-enable, and the one-step window in which frame_base may change are each fixed by the register contents alone.

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer #(
  parameter int CW = 12,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pix_strobe,
  output logic          pclk_edge_inv,
  output logic          lcd_power,
  output logic          irq,
  output logic [31:0]   frame_base
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] A_HOR = AW'(0);
  localparam logic [AW-1:0] A_VER = AW'(1);
  localparam logic [AW-1:0] A_POL = AW'(2);
  localparam logic [AW-1:0] A_CTL = AW'(3);
  localparam logic [AW-1:0] A_BAS = AW'(4);
  localparam logic [AW-1:0] A_IEN = AW'(5);
  localparam logic [AW-1:0] A_ICL = AW'(6);

  logic [31:0] hor_r, ver_r, pol_r, shadow_r, live_r;
  logic        en, pwr, ien, stat;
  logic [CW-1:0] hc, vc;

  logic [6:0]    blocks;
  logic [CW-1:0] h_act, h_fp_end, h_sw_end, h_tot;
  logic [CW-1:0] v_act, v_fp_end, v_sw_end, v_tot;
  logic          h_last, v_last, adopt;
  logic          hs_raw, vs_raw, de_raw;

  assign blocks   = {1'b0, hor_r[7:2]} + 7'd1;
  assign h_act    = CW'({blocks, 4'b0000});
  assign h_fp_end = h_act    + CW'(hor_r[23:16]) + ONE;
  assign h_sw_end = h_fp_end + CW'(hor_r[15:8])  + ONE;
  assign h_tot    = h_sw_end + CW'(hor_r[31:24]) + ONE;

  assign v_act    = CW'(ver_r[9:0]) + ONE;
  assign v_fp_end = v_act    + CW'(ver_r[23:16]);
  assign v_sw_end = v_fp_end + CW'(ver_r[15:10]) + ONE;
  assign v_tot    = v_sw_end + CW'(ver_r[31:24]);

  assign h_last = hc >= h_tot - ONE;
  assign v_last = vc >= v_tot - ONE;
  assign adopt  = en && pix_en && h_last && (vc == v_act - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0;
      vc <= '0;
    end else if (!en) begin
      hc <= '0;
      vc <= '0;
    end else if (pix_en) begin
      if (h_last) begin
        hc <= '0;
        vc <= v_last ? '0 : vc + ONE;
      end else begin
        hc <= hc + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hor_r    <= '0;
      ver_r    <= '0;
      pol_r    <= '0;
      en       <= 1'b0;
      pwr      <= 1'b0;
      shadow_r <= '0;
      ien      <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_HOR: hor_r <= wr_data;
        A_VER: ver_r <= wr_data;
        A_POL: pol_r <= wr_data;
        A_CTL: begin
          en  <= wr_data[0];
          pwr <= wr_data[1];
        end
        A_BAS: shadow_r <= {wr_data[31:2], 2'b00};
        A_IEN: ien <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_r <= '0;
      stat   <= 1'b0;
    end else if (adopt) begin
      live_r <= shadow_r;
      stat   <= 1'b1;
    end else if (wr_en && wr_addr == A_ICL && wr_data[0]) begin
      stat <= 1'b0;
    end
  end

  assign hs_raw = en && hc >= h_fp_end && hc < h_sw_end;
  assign vs_raw = en && vc >= v_fp_end && vc < v_sw_end;
  assign de_raw = en && hc < h_act && vc < v_act;

  assign hsync         = hs_raw ^ pol_r[0];
  assign vsync         = vs_raw ^ pol_r[1];
  assign de            = de_raw ^ pol_r[2];
  assign pclk_edge_inv = pol_r[3];
  assign pix_strobe    = de_raw && pix_en && (hc <= CW'(pol_r[25:16]));
  assign lcd_power     = pwr;
  assign irq           = stat & ien;
  assign frame_base    = live_r;
endmodule

// File: rtl/lcd_raster_timer_sva.sv
module lcd_raster_timer_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        pix_en,
  input logic        hsync,
  input logic        vsync,
  input logic        de,
  input logic        pix_strobe,
  input logic        irq,
  input logic        ien,
  input logic        stat,
  input logic        adopt,
  input logic [2:0]  inv,
  input logic [31:0] frame_base
);
  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (hsync == inv[0] && vsync == inv[1] && de == inv[2])); // R8
  AST_STROBE_IN_DE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_strobe |-> (pix_en && de != inv[2])); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien); // R10
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_base[1:0] == 2'b00); // R9
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adopt |=> $stable(frame_base)); // R9
  AST_STATUS_ON_ADOPT: assert property (@(posedge clk) disable iff (!rst_n)
    adopt |=> stat); // R10
endmodule

bind lcd_raster_timer lcd_raster_timer_sva u_sva (
  .clk(clk), .rst_n(rst_n), .en(en), .pix_en(pix_en),
  .hsync(hsync), .vsync(vsync), .de(de), .pix_strobe(pix_strobe),
  .irq(irq), .ien(ien), .stat(stat), .adopt(adopt),
  .inv(pol_r[2:0]), .frame_base(frame_base)
);

// File: tb/lcd_raster_timer_test.sv
`timescale 1ns/1ps
module lcd_raster_timer_test;
  typedef struct packed {
    logic hs, vs, de, st, irq;
    logic [31:0] base;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, pix_en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic hsync, vsync, de, pix_strobe, pclk_edge_inv, lcd_power, irq;
  logic [31:0] frame_base;

  int checks = 0, fails = 0;
  bit done = 0;
  item_t q[$];

  int hA, hF, hS, hB, vA, vF, vS, vB, cpl, h, v;
  bit ih, iv, ide, stat_m, ien_m;
  logic [31:0] shadow_m, base_m;

  always #10 clk = ~clk;

  lcd_raster_timer uut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .hsync(hsync), .vsync(vsync),
    .de(de), .pix_strobe(pix_strobe), .pclk_edge_inv(pclk_edge_inv),
    .lcd_power(lcd_power), .irq(irq), .frame_base(frame_base)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic item_t expect_now(input bit p);
    item_t it;
    bit hv, vv;
    hv = h < hA;
    vv = v < vA;
    it.hs   = (h >= hA + hF && h < hA + hF + hS) ^ ih;
    it.vs   = (v >= vA + vF && v < vA + vF + vS) ^ iv;
    it.de   = (hv && vv) ^ ide;
    it.st   = hv && vv && (h <= cpl) && p;
    it.irq  = stat_m && ien_m;
    it.base = base_m;
    return it;
  endfunction

  // driver: one pixel-clock-enable decision per cycle; gaps exercise R7
  task automatic step(input bit p);
    pix_en = p;
    if (p) begin
      if (h == hA + hF + hS + hB - 1 && v == vA - 1) begin
        base_m = shadow_m;
        stat_m = 1;
      end
      if (h == hA + hF + hS + hB - 1) begin
        h = 0;
        v = (v == vA + vF + vS + vB - 1) ? 0 : v + 1;
      end else h = h + 1;
    end
    q.push_back(expect_now(p));
    @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    item_t e;
    #5;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(hsync == e.hs, "R2/R5 hsync", 32'(hsync), 32'(e.hs));
      chk(vsync == e.vs, "R3/R5 vsync", 32'(vsync), 32'(e.vs));
      chk(de == e.de, "R4 de", 32'(de), 32'(e.de));
      chk(pix_strobe == e.st, "R6 strobe", 32'(pix_strobe), 32'(e.st));
      chk(irq == e.irq, "R10 irq", 32'(irq), 32'(e.irq));
      chk(frame_base == e.base, "R9 base", frame_base, e.base);
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    stat_m = 0; ien_m = 0; base_m = '0; shadow_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(hsync == 0 && vsync == 0 && de == 0, "R1 sync idle", {hsync, vsync, de}, 0);
    chk(pix_strobe == 0 && irq == 0 && lcd_power == 0, "R1 flags", {pix_strobe, irq, lcd_power}, 0);
    chk(frame_base == 0, "R1 base", frame_base, 0);

    // configuration A
    hA = 16; hF = 1; hS = 2; hB = 3; vA = 3; vF = 1; vS = 1; vB = 2; cpl = 15;
    ih = 0; iv = 0; ide = 0;
    wr(3'd0, {8'd2, 8'd0, 8'd1, 6'd0, 2'b00});
    wr(3'd1, {8'd2, 8'd1, 6'd0, 10'd2});
    wr(3'd2, {6'd0, 10'd15, 16'h0000});
    wr(3'd5, 32'd0);
    wr(3'd4, 32'h1000_0007);
    shadow_m = 32'h1000_0004;
    chk(frame_base == 0, "R9 base held before blanking", frame_base, 0);
    wr(3'd3, 32'd3);
    chk(lcd_power == 1, "R8 power on", 32'(lcd_power), 1);
    h = 0; v = 0;
    for (int i = 0; i < 170; i++) step(i % 5 != 3);
    pix_en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(irq == 0, "R10 masked status", 32'(irq), 0);
    wr(3'd5, 32'd1); ien_m = 1;
    chk(irq == 1, "R10 status kept while masked", 32'(irq), 1);
    wr(3'd6, 32'd1); stat_m = 0;
    chk(irq == 0, "R10 clear", 32'(irq), 0);

    // disable, R8
    wr(3'd3, 32'd0);
    chk(hsync == 0 && vsync == 0 && de == 0, "R8 idle levels", {hsync, vsync, de}, 0);
    chk(lcd_power == 0, "R8 power off", 32'(lcd_power), 0);

    // configuration B: inverted polarities, unbiased zero porches
    hA = 32; hF = 2; hS = 1; hB = 1; vA = 2; vF = 0; vS = 2; vB = 0; cpl = 20;
    ih = 1; iv = 1; ide = 1;
    wr(3'd0, {8'd0, 8'd1, 8'd0, 6'd1, 2'b00});
    wr(3'd1, {8'd0, 8'd0, 6'd1, 10'd1});
    wr(3'd2, {6'd0, 10'd20, 12'd0, 4'hF});
    chk(hsync == 1 && vsync == 1 && de == 1, "R5/R8 inverted idle", {hsync, vsync, de}, 3'b111);
    chk(pclk_edge_inv == 1, "R5 pclk edge", 32'(pclk_edge_inv), 1);
    wr(3'd4, 32'h2000_0012);
    shadow_m = 32'h2000_0010;
    wr(3'd3, 32'd1);
    h = 0; v = 0;
    for (int i = 0; i < 300; i++) step(i % 7 != 0);
    pix_en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(lcd_power == 0, "R8 power bit clear", 32'(lcd_power), 0);
    chk(frame_base == 32'h2000_0010, "R9 base adopted", frame_base, 32'h2000_0010);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule